// File: doc/BRIEF.md
# Column-indexed cache-line word shuffler

The shuffler permutes the eight 64-bit words of a cache line before they are spread across the chips of a memory module. The permutation depends only on the row-buffer column ID that the line is written to. Because of this, a strided gather that later collects one word per column lands on a different chip for every column, and all chips can answer in parallel. No state is kept from one access to the next. The output is a pure function of the column ID and the line.

The permutation is a cascade of conditional swap stages, one stage per bit of the word index. The lowest stage exchanges neighbouring single words, the next exchanges neighbouring pairs, and the top stage exchanges neighbouring quads. Each stage is switched on by the matching low bit of the column ID. Every stage is its own inverse and the stages commute. The read path therefore restores the original word order by passing the fetched line through the same block with the same column ID.

An optional output register is selected by a parameter. With the register present, the result and its valid flag appear exactly one clock after the input.

Top module: `cls_shuffler`

## Requirements
- R1: With the output register present, the output line one cycle after an accepted input (in_valid high) drives chip i with input word (i XOR c), where c is the low three bits of col_id. Word i occupies bits [64*i+63 : 64*i] of both line buses.
- R2: When the low three column bits are all zero, no stage is active and the output line equals the input line.
- R3: Column ID bits above bit 2 have no effect on the output line.
- R4: Feeding the output line back in with the same column ID returns the original line, for every value 0 to 7 of the low three column bits.
- R5: Take eight consecutive columns starting at a multiple of 8. For the column at offset k, pick word (s*k mod 8). For a stride s of 2 and for a stride s of 4, these eight picked words land on eight distinct chips.
- R6: out_valid equals the value in_valid had one cycle earlier.
- R7: While rst_n is low, out_valid and line_out are zero.
- R8: While in_valid is low, line_out holds its last value whatever line_in and col_id do.
- R9: With exactly one low column bit set (values 1, 2 or 4), only that stage acts. Value 1 swaps single neighbours, value 2 swaps neighbouring pairs, and value 4 swaps the two halves of the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input line and column ID are valid |
| col_id | input | COL_W (10) | Row-buffer column ID; only the low three bits steer the stages |
| line_in | input | WORD_W*NUM_WORDS (512) | Input cache line, word i in slice i |
| out_valid | output | 1 | Output line is valid |
| line_out | output | WORD_W*NUM_WORDS (512) | Shuffled line, slice i drives chip i |

## Verification
The assertions assume that rst_n is low at the first clock edge and that col_id and line_in are steady around the active edge whenever in_valid is high. The bench changes every input only on the falling clock edge. It asserts reset from time zero, so the reset and delay properties never look at values from before the first edge. The bench drives in_valid low between bursts, and it changes line_in and col_id while in_valid is low, so that the hold property is tested against inputs that are actually moving.

// File: rtl/cls_pkg.sv
package cls_pkg;

  // Destination chip of input word word_idx for a given column.
  // The stages commute, so their combined effect is an XOR of the word index.
  function automatic int unsigned chip_of(input int unsigned word_idx,
                                          input int unsigned col,
                                          input int unsigned stages);
    int unsigned mask;
    mask = (32'd1 << stages) - 32'd1;
    return (word_idx ^ col) & mask;
  endfunction

  // Group size exchanged by stage n (n counts from 0).
  function automatic int unsigned group_of(input int unsigned stage_idx);
    return 32'd1 << stage_idx;
  endfunction

endpackage

// File: rtl/cls_swap_stage.sv
module cls_swap_stage #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  parameter int GROUP     = 1
) (
  input  logic                        en,
  input  logic [WORD_W*NUM_WORDS-1:0] d,
  output logic [WORD_W*NUM_WORDS-1:0] q
);
  // Exchanging neighbouring groups of GROUP words is the same as
  // flipping bit log2(GROUP) of every word index.
  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    localparam int SRC = i ^ GROUP;
    assign q[i*WORD_W +: WORD_W] = en ? d[SRC*WORD_W +: WORD_W]
                                      : d[i*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/cls_swap_net.sv
module cls_swap_net #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  localparam int STAGES   = $clog2(NUM_WORDS),
  localparam int LINE_W   = WORD_W * NUM_WORDS
) (
  input  logic [STAGES-1:0] stage_en,
  input  logic [LINE_W-1:0] d,
  output logic [LINE_W-1:0] q
);
  logic [LINE_W-1:0] chain [STAGES+1];

  assign chain[0] = d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    cls_swap_stage #(
      .WORD_W   (WORD_W),
      .NUM_WORDS(NUM_WORDS),
      .GROUP    (1 << s)
    ) u_stage (
      .en(stage_en[s]),
      .d (chain[s]),
      .q (chain[s+1])
    );
  end

  assign q = chain[STAGES];
endmodule

// File: rtl/cls_out_stage.sv
module cls_out_stage #(
  parameter int LINE_W  = 512,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              v_in,
  input  logic [LINE_W-1:0] d,
  output logic              v_out,
  output logic [LINE_W-1:0] q
);
  if (OUT_REG) begin : g_reg
    logic              v_q;
    logic [LINE_W-1:0] d_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        v_q <= v_in;
        if (v_in) d_q <= d;
      end
    end
    assign v_out = v_q;
    assign q     = d_q;
  end else begin : g_comb
    assign v_out = rst_n & v_in;
    assign q     = rst_n ? d : '0;
  end
endmodule

// File: rtl/cls_shuffler.sv
module cls_shuffler #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  parameter int COL_W     = 10,
  parameter bit OUT_REG   = 1'b1,
  localparam int STAGES   = $clog2(NUM_WORDS),
  localparam int LINE_W   = WORD_W * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COL_W-1:0]  col_id,
  input  logic [LINE_W-1:0] line_in,
  output logic              out_valid,
  output logic [LINE_W-1:0] line_out
);
  // Named internal events, brought out for the checker.
  logic [STAGES-1:0] stage_active;
  logic [LINE_W-1:0] shuffled_line;

  assign stage_active = col_id[STAGES-1:0];

  cls_swap_net #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS)
  ) u_net (
    .stage_en(stage_active),
    .d       (line_in),
    .q       (shuffled_line)
  );

  cls_out_stage #(
    .LINE_W (LINE_W),
    .OUT_REG(OUT_REG)
  ) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .v_in (in_valid),
    .d    (shuffled_line),
    .v_out(out_valid),
    .q    (line_out)
  );
endmodule

// File: rtl/cls_shuffler_chk.sv
module cls_shuffler_chk #(
  parameter int WORD_W    = 64,
  parameter int NUM_WORDS = 8,
  parameter int COL_W     = 10,
  parameter bit OUT_REG   = 1'b1,
  localparam int STAGES   = $clog2(NUM_WORDS),
  localparam int LINE_W   = WORD_W * NUM_WORDS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [COL_W-1:0]  col_id,
  input logic [LINE_W-1:0] line_in,
  input logic              out_valid,
  input logic [LINE_W-1:0] line_out,
  input logic [STAGES-1:0] stage_active
);
  import cls_pkg::*;

  // Input word that chip 0 must receive: chip_of(j, c) == 0 holds when j == c.
  logic [WORD_W-1:0] chip0_src;
  always_comb begin
    chip0_src = '0;
    for (int j = 0; j < NUM_WORDS; j++)
      if (chip_of(j, 32'(col_id), STAGES) == 0)
        chip0_src = line_in[j*WORD_W +: WORD_W];
  end

  if (OUT_REG) begin : g_reg_chk
    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
    // R6
    idle_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && stage_active == '0) |=> line_out == $past(line_in));
    // R1
    chip0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> line_out[WORD_W-1:0] == $past(chip0_src));
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(line_out));
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && line_out == '0));
  end else begin : g_comb_chk
    // R6
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);
    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_active == '0) |-> line_out == line_in);
    // R1
    chip0_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_out[WORD_W-1:0] == chip0_src);
    // R7
    reset_clear_chk: assert property (@(posedge clk)
      !rst_n |-> (!out_valid && line_out == '0));
  end
endmodule

bind cls_shuffler cls_shuffler_chk #(
  .WORD_W   (WORD_W),
  .NUM_WORDS(NUM_WORDS),
  .COL_W    (COL_W),
  .OUT_REG  (OUT_REG)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .col_id      (col_id),
  .line_in     (line_in),
  .out_valid   (out_valid),
  .line_out    (line_out),
  .stage_active(stage_active)
);

// File: tb/cls_shuffler_tb.sv
module cls_shuffler_tb;
  localparam int WORD_W    = 64;
  localparam int NUM_WORDS = 8;
  localparam int COL_W     = 10;
  localparam int LINE_W    = WORD_W * NUM_WORDS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [COL_W-1:0]  col_id = '0;
  logic [LINE_W-1:0] line_in = '0;
  logic              out_valid;
  logic [LINE_W-1:0] line_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cls_shuffler #(
    .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .COL_W(COL_W), .OUT_REG(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .col_id(col_id),
    .line_in(line_in), .out_valid(out_valid), .line_out(line_out)
  );

  function automatic logic [LINE_W-1:0] make_line(input int seed);
    logic [LINE_W-1:0] l;
    for (int j = 0; j < NUM_WORDS; j++)
      l[j*WORD_W +: WORD_W] = {32'(seed) * 32'h9E37_79B9 + 32'h1234_0000, 32'(j)};
    return l;
  endfunction

  // Forward mapping: input word j travels to chip (j mod 8) flipped by the set column bits.
  function automatic logic [LINE_W-1:0] exp_line(input logic [LINE_W-1:0] l,
                                                 input int c);
    logic [LINE_W-1:0] e;
    int dst;
    e = '0;
    for (int j = 0; j < NUM_WORDS; j++) begin
      dst = j;
      if (c % 2 == 1)       dst = (dst % 2 == 0) ? dst + 1 : dst - 1;
      if ((c / 2) % 2 == 1) dst = ((dst / 2) % 2 == 0) ? dst + 2 : dst - 2;
      if ((c / 4) % 2 == 1) dst = (dst < 4) ? dst + 4 : dst - 4;
      e[dst*WORD_W +: WORD_W] = l[j*WORD_W +: WORD_W];
    end
    return e;
  endfunction

  task automatic chk(input string req, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // Apply one line for one cycle and return the registered result.
  task automatic drive(input logic [COL_W-1:0] c, input logic [LINE_W-1:0] l,
                       output logic [LINE_W-1:0] r);
    @(negedge clk);
    in_valid = 1'b1;
    col_id   = c;
    line_in  = l;
    @(posedge clk);
    #1;
    r = line_out;
    chk1("R6 valid after accept", out_valid, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R6 watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [LINE_W-1:0] l, r, back, held;
    // R7: reset state
    repeat (3) @(posedge clk);
    #1;
    chk1("R7 reset out_valid", out_valid, 1'b0);
    chk("R7 reset line_out", line_out, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1, R2, R9, R4: every column value with several line patterns
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 3; p++) begin
        l = make_line(c * 3 + p + 1);
        drive(COL_W'(c), l, r);
        chk("R1 permutation", r, exp_line(l, c));
        if (c == 0) chk("R2 passthrough", r, l);
        if (c == 1 || c == 2 || c == 4) chk("R9 single stage", r, exp_line(l, c));
        drive(COL_W'(c), r, back);
        chk("R4 round trip", back, l);
      end
    end

    // R3: high column bits ignored
    for (int k = 1; k < 8; k++) begin
      for (int c = 0; c < 8; c++) begin
        l = make_line(100 + c);
        drive(COL_W'((k * 37) << 3) | COL_W'(c), l, r);
        chk("R3 high column bits ignored", r, exp_line(l, c));
      end
    end

    // R8 and R6: hold while idle, valid low
    l = make_line(77);
    drive(COL_W'(5), l, held);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      line_in = make_line(200 + i);
      col_id  = COL_W'(i * 3);
    end
    @(posedge clk);
    #1;
    chk("R8 hold while idle", line_out, held);
    chk1("R6 valid low while idle", out_valid, 1'b0);

    // R5: stride-2 and stride-4 gathers over eight aligned columns
    for (int s = 2; s <= 4; s += 2) begin
      logic [7:0] hit;
      hit = '0;
      for (int k = 0; k < 8; k++) begin
        int w, found;
        w = (s * k) % 8;
        l = make_line(300 + k);
        drive(COL_W'(24 + k), l, r);
        found = -1;
        for (int ch = 0; ch < NUM_WORDS; ch++)
          if (r[ch*WORD_W +: WORD_W] == l[w*WORD_W +: WORD_W]) found = ch;
        checks++;
        if (found < 0 || hit[found[2:0]]) begin
          errors++;
          $display("FAIL R5 stride %0d elem %0d chip=%0d hitmask=%b exp=new chip",
                   s, k, found, hit);
        end else begin
          hit[found[2:0]] = 1'b1;
        end
      end
      checks++;
      if (hit != 8'hFF) begin
        errors++;
        $display("FAIL R5 stride %0d chips act=%b exp=11111111", s, hit);
      end
    end

    // R7: reset in mid-run clears registered output
    l = make_line(999);
    drive(COL_W'(3), l, r);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk1("R7 mid-run reset out_valid", out_valid, 1'b0);
    chk("R7 mid-run reset line_out", line_out, '0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(COL_W'(6), l, r);
    chk("R1 after reset", r, exp_line(l, 6));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule